// File: doc/BRIEF.md
# Supply and Watchdog Reset Generator

This block drives the reset of a microcontroller from two sources. A supply-good flag, already digitized by an external comparator, covers power-on and brownout. While the flag is low, reset is held. Reset is released only after the flag has stayed high without a break for a programmable hold time, nominally 200 ms.

The second source is a watchdog that watches the chip-select/strobe line. Each falling edge of that line restarts the watchdog count. If the line sits at one level, high or low, for longer than the selected period, reset fires and is held for the same hold time. A 2-bit code selects the period, and one value of the code turns the watchdog off.

All timing runs in units of a millisecond tick taken from the system clock, so a simulation can shrink every interval. The reset is presented twice, once active low and once active high.

Top module: `supv_reset_gen`

## Requirements
- R1: Within 4 clock cycles of `vcc_ok` going low, `rst_o` is 1, and it stays 1 while `vcc_ok` stays low.
- R2: After `vcc_ok` rises, reset is released between HOLD_MS-1 and HOLD_MS+1 ticks later. A release is never seen unless `vcc_ok` has been high for at least (HOLD_MS-1) ticks.
- R3: A low pulse on `vcc_ok` of 2 cycles or more during the hold interval restarts the hold. Release then needs a full uninterrupted hold from the last rise.
- R4: `wd_sel` selects the watchdog period: 2'b00 gives LONG_MS, 2'b01 gives MID_MS, 2'b10 gives SHORT_MS (nominally 1400, 600 and 200 ms).
- R5: With `wd_sel` = 2'b11 the watchdog is off and never asserts reset.
- R6: A high-to-low transition of `cs_wdi` restarts the watchdog count. Strobing faster than the period keeps reset released.
- R7: If `cs_wdi` stays constant, either high or low, for longer than the period, reset is asserted. It rises between period-1 and period+1 ticks after the count started.
- R8: After a watchdog expiry, reset is held for HOLD_MS ticks (±1 tick) and is then released.
- R9: `rst_n_o` is always the inverse of `rst_o`.
- R10: The watchdog count is held at zero while reset is asserted. After release, a full period passes before the next expiry.
- R11: Any change of `wd_sel` restarts the watchdog count, so switching to a shorter period does not cause an immediate timeout.
- R12: While `sys_rst` is high, and directly after it, reset is asserted (`rst_o`=1, `rst_n_o`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| sys_rst | input | 1 | Synchronous active-high reset of the block |
| vcc_ok | input | 1 | Supply-good flag from the external comparator, asynchronous |
| cs_wdi | input | 1 | Chip-select/strobe observed by the watchdog, asynchronous |
| wd_sel | input | 2 | Watchdog period code (00 long, 01 mid, 10 short, 11 off) |
| rst_n_o | output | 1 | Reset, active low |
| rst_o | output | 1 | Reset, active high |

## Verification
Two pairs of events can land in the same cycle. The first pair is a change of period code and a watchdog count that has already passed the new, shorter limit. The second pair is a strobe falling edge and an active reset hold.

The bench provokes the first pair by letting the count run most of a mid-length period and then switching to the short code. It then checks that the next reset comes a full short period after the switch. The second pair is provoked by moving the strobe level during a forced supply dropout. The bench then measures that the expiry after release still takes a full period.

// File: rtl/supv_pkg.sv
package supv_pkg;
  typedef enum logic [1:0] {
    WD_LONG  = 2'b00,
    WD_MID   = 2'b01,
    WD_SHORT = 2'b10,
    WD_OFF   = 2'b11
  } wd_sel_e;
endpackage

// File: rtl/supv_tick.sv
// Divides the system clock into a one-cycle pulse every TICK_CYCLES cycles.
module supv_tick #(
  parameter int TICK_CYCLES = 50000
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  generate
    if (TICK_CYCLES <= 1) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int DW = $clog2(TICK_CYCLES);
      logic [DW-1:0] div_q;
      logic          tick_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          div_q  <= '0;
          tick_q <= 1'b0;
        end else if (div_q == DW'(TICK_CYCLES - 1)) begin
          div_q  <= '0;
          tick_q <= 1'b1;
        end else begin
          div_q  <= div_q + 1'b1;
          tick_q <= 1'b0;
        end
      end
      assign tick_o = tick_q;
    end
  endgenerate
endmodule

// File: rtl/supv_sync.sv
// Multi-stage synchronizer for an asynchronous level.
module supv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], d_i};
  end
  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/supv_wdog.sv
// Watchdog counter in tick units. A falling strobe edge restarts it, and so
// do a code change, an active reset and the off code.
module supv_wdog
  import supv_pkg::*;
#(
  parameter int LONG_MS  = 1400,
  parameter int MID_MS   = 600,
  parameter int SHORT_MS = 200
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    tick_i,
  input  logic    cs_s_i,
  input  wd_sel_e sel_i,
  input  logic    hold_clr_i,
  output logic    expire_o
);
  localparam int MAX_A = (LONG_MS > MID_MS) ? LONG_MS : MID_MS;
  localparam int MAX_MS = (MAX_A > SHORT_MS) ? MAX_A : SHORT_MS;
  localparam int CW = $clog2(MAX_MS + 1);

  logic          cs_prev_q;
  wd_sel_e       sel_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;
  logic          fall;
  logic          restart;
  logic          expire_q;

  always_comb begin
    case (sel_i)
      WD_LONG:  limit = CW'(LONG_MS - 1);
      WD_MID:   limit = CW'(MID_MS - 1);
      WD_SHORT: limit = CW'(SHORT_MS - 1);
      default:  limit = '1;
    endcase
  end

  assign fall    = cs_prev_q & ~cs_s_i;
  assign restart = hold_clr_i | fall | (sel_i != sel_q) | (sel_i == WD_OFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_prev_q <= 1'b0;
      sel_q     <= WD_OFF;
      cnt_q     <= '0;
      expire_q  <= 1'b0;
    end else begin
      cs_prev_q <= cs_s_i;
      sel_q     <= sel_i;
      expire_q  <= 1'b0;
      if (restart) begin
        cnt_q <= '0;
      end else if (tick_i) begin
        if (cnt_q >= limit) begin
          expire_q <= 1'b1;
          cnt_q    <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
  assign expire_o = expire_q;
endmodule

// File: rtl/supv_hold.sv
// Reset state with the shared stretch timer: any low supply or watchdog
// expiry (re)starts it, and release follows HOLD_MS quiet ticks.
module supv_hold #(
  parameter int HOLD_MS = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic vcc_s_i,
  input  logic wd_expire_i,
  output logic active_o
);
  localparam int HW = $clog2(HOLD_MS + 1);
  logic [HW-1:0] cnt_q;
  logic          active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (!vcc_s_i || wd_expire_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (active_q && tick_i) begin
      if (cnt_q == HW'(HOLD_MS - 1)) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
  assign active_o = active_q;
endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen
  import supv_pkg::*;
#(
  parameter int TICK_CYCLES = 50000,
  parameter int HOLD_MS     = 200,
  parameter int LONG_MS     = 1400,
  parameter int MID_MS      = 600,
  parameter int SHORT_MS    = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       sys_rst,
  input  logic       vcc_ok,
  input  logic       cs_wdi,
  input  logic [1:0] wd_sel,
  output logic       rst_n_o,
  output logic       rst_o
);
  logic tick;
  logic vcc_s;
  logic cs_s;
  logic wd_expire;
  logic active;
  logic rst_q;
  logic rst_n_q;

  supv_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk(clk), .rst(sys_rst), .tick_o(tick)
  );

  supv_sync #(.STAGES(SYNC_STAGES)) u_sync_vcc (
    .clk(clk), .rst(sys_rst), .d_i(vcc_ok), .q_o(vcc_s)
  );

  supv_sync #(.STAGES(SYNC_STAGES)) u_sync_cs (
    .clk(clk), .rst(sys_rst), .d_i(cs_wdi), .q_o(cs_s)
  );

  supv_wdog #(.LONG_MS(LONG_MS), .MID_MS(MID_MS), .SHORT_MS(SHORT_MS)) u_wdog (
    .clk(clk), .rst(sys_rst), .tick_i(tick), .cs_s_i(cs_s),
    .sel_i(wd_sel_e'(wd_sel)), .hold_clr_i(active), .expire_o(wd_expire)
  );

  supv_hold #(.HOLD_MS(HOLD_MS)) u_hold (
    .clk(clk), .rst(sys_rst), .tick_i(tick), .vcc_s_i(vcc_s),
    .wd_expire_i(wd_expire), .active_o(active)
  );

  always_ff @(posedge clk) begin
    if (sys_rst) begin
      rst_q   <= 1'b1;
      rst_n_q <= 1'b0;
    end else begin
      rst_q   <= active;
      rst_n_q <= ~active;
    end
  end

  assign rst_o   = rst_q;
  assign rst_n_o = rst_n_q;
endmodule

// File: rtl/supv_reset_chk.sv
module supv_reset_chk #(
  parameter int TICK_CYCLES = 50000,
  parameter int HOLD_MS     = 200,
  parameter int LONG_MS     = 1400,
  parameter int MID_MS      = 600,
  parameter int SHORT_MS    = 200
) (
  input logic       clk,
  input logic       sys_rst,
  input logic       vcc_ok,
  input logic       cs_wdi,
  input logic [1:0] wd_sel,
  input logic       rst_n_o,
  input logic       rst_o
);
  localparam int CAP = 1 << 30;
  int   vcc_run;
  int   quiet;
  int   sel_run;
  logic cs_q;
  logic [1:0] sel_q;

  function automatic int min_cycles(input logic [1:0] s);
    case (s)
      2'b00:   return (LONG_MS - 1) * TICK_CYCLES - 4;
      2'b01:   return (MID_MS - 1) * TICK_CYCLES - 4;
      2'b10:   return (SHORT_MS - 1) * TICK_CYCLES - 4;
      default: return CAP;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (sys_rst) begin
      vcc_run <= 0;
      quiet   <= 0;
      sel_run <= 0;
      cs_q    <= 1'b0;
      sel_q   <= 2'b11;
    end else begin
      cs_q  <= cs_wdi;
      sel_q <= wd_sel;
      vcc_run <= !vcc_ok ? 0 : (vcc_run < CAP ? vcc_run + 1 : vcc_run);
      sel_run <= (wd_sel != sel_q) ? 0 : (sel_run < CAP ? sel_run + 1 : sel_run);
      if (rst_o || (cs_q && !cs_wdi) || (wd_sel != sel_q)) quiet <= 0;
      else if (quiet < CAP) quiet <= quiet + 1;
    end
  end

  // R9
  comp_out_chk: assert property (@(posedge clk) disable iff (sys_rst)
    rst_o == !rst_n_o);

  // R1
  vcc_low_chk: assert property (@(posedge clk) disable iff (sys_rst)
    ($past(vcc_ok, 4) == 1'b0) |-> rst_o);

  // R2
  hold_min_chk: assert property (@(posedge clk) disable iff (sys_rst)
    $fell(rst_o) |-> (vcc_run >= (HOLD_MS - 1) * TICK_CYCLES));

  // R7
  wd_min_chk: assert property (@(posedge clk) disable iff (sys_rst)
    ($rose(rst_o) && vcc_run >= 8) |-> (quiet >= min_cycles(wd_sel)));

  // R5
  wd_off_chk: assert property (@(posedge clk) disable iff (sys_rst)
    (wd_sel == 2'b11 && sel_run >= 8 && vcc_run >= 8) |-> !$rose(rst_o));
endmodule

bind supv_reset_gen supv_reset_chk #(
  .TICK_CYCLES(TICK_CYCLES), .HOLD_MS(HOLD_MS),
  .LONG_MS(LONG_MS), .MID_MS(MID_MS), .SHORT_MS(SHORT_MS)
) u_chk (
  .clk(clk), .sys_rst(sys_rst), .vcc_ok(vcc_ok), .cs_wdi(cs_wdi),
  .wd_sel(wd_sel), .rst_n_o(rst_n_o), .rst_o(rst_o)
);

// File: tb/tb_supv_reset_gen.sv
module tb_supv_reset_gen;
  localparam int T  = 4;
  localparam int HM = 10;
  localparam int LM = 40;
  localparam int MM = 25;
  localparam int SM = 15;

  localparam int NV = 4;
  localparam logic [1:0] V_SEL[NV] = '{2'b10, 2'b01, 2'b00, 2'b11};
  localparam logic       V_CS [NV] = '{1'b1, 1'b0, 1'b1, 1'b0};
  localparam int         V_MS [NV] = '{SM, MM, LM, 0};

  logic       clk = 1'b0;
  logic       sys_rst;
  logic       vcc_ok;
  logic       cs_wdi;
  logic [1:0] wd_sel;
  logic       rst_n_o;
  logic       rst_o;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  supv_reset_gen #(
    .TICK_CYCLES(T), .HOLD_MS(HM), .LONG_MS(LM), .MID_MS(MM), .SHORT_MS(SM)
  ) dut (
    .clk(clk), .sys_rst(sys_rst), .vcc_ok(vcc_ok), .cs_wdi(cs_wdi),
    .wd_sel(wd_sel), .rst_n_o(rst_n_o), .rst_o(rst_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_win(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  // counts negedges until rst_o equals lvl, up to maxc
  task automatic wait_lvl(input logic lvl, input int maxc, output int n);
    n = 0;
    while (rst_o !== lvl && n < maxc) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic idle(input int c, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < c; i++) begin
      @(negedge clk);
      if (rst_o) seen = 1'b1;
    end
  endtask

  task automatic rearm;
    int n;
    vcc_ok = 1'b0;
    repeat (6) @(negedge clk);
    vcc_ok = 1'b1;
    wait_lvl(1'b0, 200, n);
  endtask

  initial begin
    int  n;
    int  m;
    bit  seen;
    sys_rst = 1'b1; vcc_ok = 1'b0; cs_wdi = 1'b0; wd_sel = 2'b11;
    repeat (5) @(negedge clk);
    // R12 reset state
    chk(rst_o == 1'b1 && rst_n_o == 1'b0, "R12", rst_o, 1);
    sys_rst = 1'b0;
    @(negedge clk);
    chk(rst_o == 1'b1, "R12", rst_o, 1);
    // R1 held while supply low
    idle(60, seen);
    chk(rst_o == 1'b1, "R1", rst_o, 1);
    // R2 release window after supply rise
    vcc_ok = 1'b1;
    wait_lvl(1'b0, 500, n);
    chk_win("R2", n, (HM - 1) * T, HM * T + 6);
    chk(rst_n_o == 1'b1, "R9", rst_n_o, 1);
    // R1 assertion latency
    vcc_ok = 1'b0;
    repeat (4) @(negedge clk);
    chk(rst_o == 1'b1, "R1", rst_o, 1);
    chk(rst_n_o == 1'b0, "R9", rst_n_o, 0);
    // R3 dropout during hold restarts it
    vcc_ok = 1'b1;
    repeat (30) @(negedge clk);
    chk(rst_o == 1'b1, "R3", rst_o, 1);
    vcc_ok = 1'b0;
    repeat (2) @(negedge clk);
    vcc_ok = 1'b1;
    repeat (32) @(negedge clk);
    chk(rst_o == 1'b1, "R3", rst_o, 1);
    wait_lvl(1'b0, 500, n);
    chk_win("R3", n + 32, (HM - 1) * T, HM * T + 6);

    // table: period code, stuck level, expected period (R4, R7, R10, R8, R5)
    for (int i = 0; i < NV; i++) begin
      wd_sel = V_SEL[i];
      cs_wdi = V_CS[i];
      rearm();
      wait_lvl(1'b1, 3 * LM * T, n);
      if (V_MS[i] == 0) begin
        chk(n == 3 * LM * T, "R5", n, 3 * LM * T);
      end else begin
        chk_win("R4_R7_R10", n, (V_MS[i] - 1) * T, (V_MS[i] + 1) * T + 4);
        chk(rst_n_o == 1'b0, "R9", rst_n_o, 0);
        wait_lvl(1'b0, 500, m);
        chk_win("R8", m, (HM - 1) * T - 1, HM * T + 4);
      end
    end

    // R6 periodic strobing keeps reset released
    wd_sel = 2'b10;
    cs_wdi = 1'b1;
    rearm();
    m = 0;
    for (int k = 0; k < 6; k++) begin
      idle(30, seen);
      if (seen) m++;
      cs_wdi = 1'b0;
      idle(10, seen);
      if (seen) m++;
      cs_wdi = 1'b1;
    end
    chk(m == 0, "R6", m, 0);

    // R11 code change restarts the count
    wd_sel = 2'b01;
    cs_wdi = 1'b0;
    rearm();
    idle(80, seen);
    chk(seen == 1'b0, "R11", seen, 0);
    wd_sel = 2'b10;
    wait_lvl(1'b1, 500, n);
    chk_win("R11", n, (SM - 1) * T, (SM + 1) * T + 8);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule